// File: doc/BRIEF.md
# Bounded Pin-Window Configuration Register

This block holds the pin-mapping settings for three groups of pin operations in a small programmable I/O engine: output-shift, set and side-set. Each group has a base pin and a pin count. The block keeps every group inside a fixed window of eight pins. No write can leave a group reaching past the last window pin.

Software-side logic writes one field at a time. It drives a field select, a data value and a write strobe. Any value outside the legal range is clamped before it is stored. When a base moves up and the existing count no longer fits, the count shrinks with it. The effective (clamped) base and count of every group are always visible on dedicated outputs. A sticky flag records that some write was altered on its way in. A separate strobe clears the flag.

Top module: `pwin_cfg`

## Requirements
- R1: After reset, output-shift and set each have base 0 and count 8; side-set has base 0, count 0 and its optional-enable bit at 0; the clamp flag is 0.
- R2: A write takes effect on the rising clock edge at which `wr_en_i` is sampled high, and only the selected field changes. The field select codes are: 0 output-shift base, 1 output-shift count, 2 set base, 3 set count, 4 side-set base, 5 side-set count, 6 side-set optional-enable (taken from data bit 0), 7 no field.
- R3: A written base is clamped to 0..7; data values 8..15 store 7.
- R4: A written output-shift or set count is clamped to the range 1..(8 − base); data 0 stores 1.
- R5: Writing a base lowers that group's count to 8 − base when the count no longer fits; lowering a base never raises the count.
- R6: A written side-set count is clamped to 0..min(M, 8 − base), where M is 5 with the optional-enable bit at 0 and 4 with it at 1.
- R7: Setting the side-set optional-enable bit while the side-set count is 5 reduces the count to 4.
- R8: The clamp flag is set by any write whose stored value differs from the data written, or that reduces a count; it then stays set.
- R9: `clr_flag_i` clears the clamp flag on the next edge; a clamping write in the same cycle takes precedence and leaves the flag set.
- R10: For every group, base + count never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Field select (codes in R2) |
| wr_data_i | input | 4 | Write value |
| clr_flag_i | input | 1 | Clears the sticky clamp flag |
| out_base_o | output | 3 | Effective output-shift base |
| out_cnt_o | output | 4 | Effective output-shift count |
| set_base_o | output | 3 | Effective set base |
| set_cnt_o | output | 4 | Effective set count |
| ss_base_o | output | 3 | Effective side-set base |
| ss_cnt_o | output | 4 | Effective side-set count |
| ss_opt_o | output | 1 | Side-set optional-enable bit |
| clamped_o | output | 1 | Sticky flag: some write was clamped |

## Verification
The bench pushes bases to 7 and beyond while the counts sit at their maximum. A design that stored a base raw, or that failed to shrink the coupled count, would then expose a window overrun. It writes count 0 to the groups that need at least one pin; a design without the floor would store 0. It toggles the side-set optional-enable bit with the count at 5, and it writes side-set counts just above each ceiling. A design that used a fixed side-set limit would keep 5. The bench also issues a clear and a clamping write in the same cycle. A design with the wrong precedence would drop the flag.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [2:0] {
    FS_OUT_BASE = 3'd0,
    FS_OUT_CNT  = 3'd1,
    FS_SET_BASE = 3'd2,
    FS_SET_CNT  = 3'd3,
    FS_SS_BASE  = 3'd4,
    FS_SS_CNT   = 3'd5,
    FS_SS_OPT   = 3'd6,
    FS_NONE     = 3'd7
  } field_e;

  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned GRP_SS  = 2;
endpackage

// File: rtl/pwin_group.sv
module pwin_group #(
  parameter int unsigned PINS    = 8,
  parameter int unsigned DW      = 4,
  parameter int unsigned BW      = 3,
  parameter int unsigned CW      = 4,
  parameter int unsigned CNT_MIN = 1,
  parameter int unsigned CNT_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic          cnt_we_i,
  input  logic          refit_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] cnt_max_i,
  output logic [BW-1:0] base_o,
  output logic [CW-1:0] cnt_o,
  output logic          clamp_o
);
  localparam int unsigned EW = DW + 1;
  localparam logic [EW-1:0] PINS_X = EW'(PINS);
  localparam logic [EW-1:0] TOP_X  = EW'(PINS - 1);
  localparam logic [EW-1:0] MIN_X  = EW'(CNT_MIN);

  logic [BW-1:0] base_q, base_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] data_x, base_x, cnt_x, max_x;
  logic [EW-1:0] req_base, room, lim, req_cnt;

  assign data_x = EW'(data_i);
  assign base_x = EW'(base_q);
  assign cnt_x  = EW'(cnt_q);
  assign max_x  = EW'(cnt_max_i);

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    clamp_o  = 1'b0;
    req_base = (data_x > TOP_X) ? TOP_X : data_x;
    // room left above the base that will hold after this edge
    room     = PINS_X - (base_we_i ? req_base : base_x);
    lim      = (max_x < room) ? max_x : room;
    req_cnt  = (data_x < MIN_X) ? MIN_X : data_x;
    if (req_cnt > lim) req_cnt = lim;

    if (base_we_i) begin
      base_d = BW'(req_base);
      if (cnt_x > lim) cnt_d = CW'(lim);
      clamp_o = (req_base != data_x) || (cnt_x > lim);
    end else if (cnt_we_i) begin
      cnt_d   = CW'(req_cnt);
      clamp_o = (req_cnt != data_x);
    end else if (refit_i) begin
      if (cnt_x > lim) begin
        cnt_d   = CW'(lim);
        clamp_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= CW'(CNT_RST);
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pwin_cfg.sv
module pwin_cfg #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DW     = 4,
  parameter int unsigned SS_MAX = 5,
  localparam int unsigned BW    = $clog2(PINS),
  localparam int unsigned CW    = $clog2(PINS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_flag_i,
  output logic [BW-1:0] out_base_o,
  output logic [CW-1:0] out_cnt_o,
  output logic [BW-1:0] set_base_o,
  output logic [CW-1:0] set_cnt_o,
  output logic [BW-1:0] ss_base_o,
  output logic [CW-1:0] ss_cnt_o,
  output logic          ss_opt_o,
  output logic          clamped_o
);
  import pwin_pkg::*;

  logic [BW-1:0] base_arr  [NUM_GRP];
  logic [CW-1:0] cnt_arr   [NUM_GRP];
  logic [NUM_GRP-1:0] clamp_vec;
  logic          opt_q, opt_we, opt_nxt, flag_q;
  logic [CW-1:0] ss_max;

  assign opt_we  = wr_en_i && (field_e'(wr_sel_i) == FS_SS_OPT);
  assign opt_nxt = opt_we ? wr_data_i[0] : opt_q;
  assign ss_max  = opt_nxt ? CW'(SS_MAX - 1) : CW'(SS_MAX);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam bit IS_SS = (g == GRP_SS);
    logic          base_we, cnt_we;
    logic [CW-1:0] cnt_max;

    assign base_we = wr_en_i && (wr_sel_i == 3'(2 * g));
    assign cnt_we  = wr_en_i && (wr_sel_i == 3'(2 * g + 1));
    assign cnt_max = IS_SS ? ss_max : CW'(PINS);

    pwin_group #(
      .PINS    (PINS),
      .DW      (DW),
      .BW      (BW),
      .CW      (CW),
      .CNT_MIN (IS_SS ? 0 : 1),
      .CNT_RST (IS_SS ? 0 : PINS)
    ) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .base_we_i (base_we),
      .cnt_we_i  (cnt_we),
      .refit_i   (IS_SS ? opt_we : 1'b0),
      .data_i    (wr_data_i),
      .cnt_max_i (cnt_max),
      .base_o    (base_arr[g]),
      .cnt_o     (cnt_arr[g]),
      .clamp_o   (clamp_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      opt_q <= opt_nxt;
      // a clamping write wins over a clear in the same cycle
      if (|clamp_vec)      flag_q <= 1'b1;
      else if (clr_flag_i) flag_q <= 1'b0;
    end
  end

  assign out_base_o = base_arr[0];
  assign out_cnt_o  = cnt_arr[0];
  assign set_base_o = base_arr[1];
  assign set_cnt_o  = cnt_arr[1];
  assign ss_base_o  = base_arr[GRP_SS];
  assign ss_cnt_o   = cnt_arr[GRP_SS];
  assign ss_opt_o   = opt_q;
  assign clamped_o  = flag_q;
endmodule

// File: rtl/pwin_cfg_chk.sv
module pwin_cfg_chk #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DW     = 4,
  parameter int unsigned SS_MAX = 5,
  parameter int unsigned BW     = 3,
  parameter int unsigned CW     = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic          clr_flag_i,
  input logic [BW-1:0] out_base_o,
  input logic [CW-1:0] out_cnt_o,
  input logic [BW-1:0] set_base_o,
  input logic [CW-1:0] set_cnt_o,
  input logic [BW-1:0] ss_base_o,
  input logic [CW-1:0] ss_cnt_o,
  input logic          ss_opt_o,
  input logic          clamped_o
);
  localparam int unsigned SW = CW + 1;

  AST_OUT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SW'(out_base_o) + SW'(out_cnt_o)) <= SW'(PINS)); // R10
  AST_SET_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SW'(set_base_o) + SW'(set_cnt_o)) <= SW'(PINS)); // R10
  AST_SS_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SW'(ss_base_o) + SW'(ss_cnt_o)) <= SW'(PINS)); // R10
  AST_CNT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt_o != '0) && (set_cnt_o != '0)); // R4
  AST_SS_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_cnt_o <= (ss_opt_o ? CW'(SS_MAX - 1) : CW'(SS_MAX))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({out_base_o, out_cnt_o, set_base_o, set_cnt_o,
                          ss_base_o, ss_cnt_o, ss_opt_o})); // R2
  AST_BASE_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> out_cnt_o <= $past(out_cnt_o)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamped_o && !clr_flag_i) |=> clamped_o); // R8
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flag_i && !wr_en_i) |=> !clamped_o); // R9
endmodule

bind pwin_cfg pwin_cfg_chk #(
  .PINS(PINS), .DW(DW), .SS_MAX(SS_MAX), .BW(BW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .clr_flag_i(clr_flag_i),
  .out_base_o(out_base_o), .out_cnt_o(out_cnt_o),
  .set_base_o(set_base_o), .set_cnt_o(set_cnt_o),
  .ss_base_o(ss_base_o), .ss_cnt_o(ss_cnt_o),
  .ss_opt_o(ss_opt_o), .clamped_o(clamped_o)
);

// File: tb/pwin_cfg_bench.sv
`timescale 1ns/1ps
module pwin_cfg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd7;
  logic [3:0] wr_data_i = 4'd0;
  logic       clr_flag_i = 1'b0;
  logic [2:0] out_base_o, set_base_o, ss_base_o;
  logic [3:0] out_cnt_o, set_cnt_o, ss_cnt_o;
  logic       ss_opt_o, clamped_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_ob, m_oc, m_sb, m_sc, m_xb, m_xc, m_opt, m_flag;

  always #2.5 clk_i = ~clk_i;

  pwin_cfg u_pwin_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .clr_flag_i(clr_flag_i),
    .out_base_o(out_base_o), .out_cnt_o(out_cnt_o),
    .set_base_o(set_base_o), .set_cnt_o(set_cnt_o),
    .ss_base_o(ss_base_o), .ss_cnt_o(ss_cnt_o),
    .ss_opt_o(ss_opt_o), .clamped_o(clamped_o)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_reset();
    m_ob = 0; m_oc = 8; m_sb = 0; m_sc = 8;
    m_xb = 0; m_xc = 0; m_opt = 0; m_flag = 0;
  endtask

  task automatic model_step(bit we, int sel, int d, bit clr);
    bit cl = 0;
    int nb, v, mx;
    if (we) begin
      mx = m_opt ? 4 : 5;
      case (sel)
        0: begin nb = imin(d, 7); cl = (nb != d); m_ob = nb;
                 if (m_oc > 8 - nb) begin m_oc = 8 - nb; cl = 1; end end
        1: begin v = (d < 1) ? 1 : imin(d, 8 - m_ob); cl = (v != d); m_oc = v; end
        2: begin nb = imin(d, 7); cl = (nb != d); m_sb = nb;
                 if (m_sc > 8 - nb) begin m_sc = 8 - nb; cl = 1; end end
        3: begin v = (d < 1) ? 1 : imin(d, 8 - m_sb); cl = (v != d); m_sc = v; end
        4: begin nb = imin(d, 7); cl = (nb != d); m_xb = nb;
                 if (m_xc > imin(mx, 8 - nb)) begin m_xc = imin(mx, 8 - nb); cl = 1; end end
        5: begin v = imin(d, imin(mx, 8 - m_xb)); cl = (v != d); m_xc = v; end
        6: begin m_opt = d % 2; mx = m_opt ? 4 : 5;
                 if (m_xc > mx) begin m_xc = mx; cl = 1; end end
        default: ;
      endcase
    end
    if (cl) m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  task automatic compare(string tag);
    logic [25:0] act, exp;
    act = {out_base_o, out_cnt_o, set_base_o, set_cnt_o, ss_base_o, ss_cnt_o,
           ss_opt_o, clamped_o};
    exp = {3'(m_ob), 4'(m_oc), 3'(m_sb), 4'(m_sc), 3'(m_xb), 4'(m_xc),
           1'(m_opt), 1'(m_flag)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (ob oc sb sc xb xc opt flag)", tag, act, exp);
    end
  endtask

  // drive at negedge, step model, check at following negedge
  task automatic cyc(bit we, int sel, int d, bit clr, string tag);
    wr_en_i = we; wr_sel_i = 3'(sel); wr_data_i = 4'(d); clr_flag_i = clr;
    model_step(we, sel, d, clr);
    @(negedge clk_i);
    wr_en_i = 1'b0; clr_flag_i = 1'b0;
    compare(tag);
  endtask

  initial begin
    bit [15:0] lfsr;
    logic [6:0] snap;
    model_reset();
    repeat (3) @(negedge clk_i);
    compare("R1 reset values held in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 reset values after release");

    // R2: nothing changes before the edge; then only the selected field
    wr_en_i = 1; wr_sel_i = 3'd1; wr_data_i = 4'd5;
    #1;
    checks++;
    if (out_cnt_o !== 4'd8) begin
      errors++; $display("FAIL R2 pre-edge out_cnt act=%0d exp=8", out_cnt_o);
    end
    model_step(1, 1, 5, 0);
    @(negedge clk_i); wr_en_i = 0;
    compare("R2 out count write at edge");
    cyc(1, 7, 15, 0, "R2 select 7 writes nothing");
    cyc(1, 3, 6, 0, "R2 set count only");
    cyc(1, 1, 8, 0, "R2 restore out count");

    // R3 base clamp, R5 coupled shrink
    cyc(1, 0, 12, 0, "R3 out base 12 -> 7, R5 count -> 1");
    cyc(0, 7, 0, 1, "R9 clear flag");
    cyc(1, 0, 2, 0, "R5 lowering base keeps count");
    cyc(1, 1, 8, 0, "R4 out count clamped to 8-base");
    cyc(1, 1, 0, 0, "R4 out count 0 -> 1");
    cyc(1, 2, 5, 0, "R5 set base 5 shrinks count");
    cyc(1, 3, 0, 0, "R4 set count 0 -> 1");
    cyc(1, 2, 7, 0, "R3 set base 7 in range");
    cyc(1, 2, 8, 0, "R3 set base 8 -> 7");

    // R6/R7 side-set
    cyc(0, 7, 0, 1, "R9 clear");
    cyc(1, 5, 5, 0, "R6 side-set count 5 ok, no flag");
    cyc(1, 5, 6, 0, "R6 side-set count 6 -> 5");
    cyc(1, 6, 1, 0, "R7 opt on shrinks 5 -> 4");
    cyc(0, 7, 0, 1, "R9 clear");
    cyc(1, 5, 5, 0, "R6 count 5 with opt -> 4");
    cyc(1, 6, 0, 0, "R7 opt off keeps count");
    cyc(1, 4, 6, 0, "R5 side-set base 6 shrinks count to 2");
    cyc(1, 5, 0, 0, "R6 side-set count 0 allowed");
    cyc(1, 4, 15, 0, "R3 side-set base 15 -> 7");

    // R8/R9 precedence and stickiness
    cyc(0, 7, 0, 1, "R9 clear");
    cyc(1, 0, 9, 1, "R9 clamping write beats clear");
    cyc(0, 7, 0, 0, "R8 flag sticky");
    cyc(1, 0, 0, 1, "R9 clear with clean write");
    snap = {out_base_o, out_cnt_o};
    cyc(0, 7, 0, 0, "R2 idle hold");
    checks++;
    if ({out_base_o, out_cnt_o} !== snap) begin
      errors++; $display("FAIL R2 idle act=%h exp=%h", {out_base_o, out_cnt_o}, snap);
    end

    // R10 pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], int'(lfsr[4:2]), int'(lfsr[8:5]), lfsr[9] & lfsr[10],
          "R10 random sweep");
    end

    // R1 again after a mid-run reset
    rst_ni = 1'b0; model_reset();
    @(negedge clk_i);
    compare("R1 reset mid-run");
    rst_ni = 1'b1;
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk_i); cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule